// File: doc/BRIEF.md
# Audio Frame Sequencer

This block paces the slow envelope and length events of a game-console audio unit. It runs on the CPU clock and keeps a half-rate phase, so its 15-bit sequence register moves once every two CPU cycles. The register is a linear-feedback shift register rather than a binary counter. Selected register values are decoded into two active-low pulses: a quarter-frame tick and a half-frame tick. In the four-step mode, the last decoded value also raises a frame interrupt flag.

The CPU reaches the block through a single write strobe that carries two control bits and a status-read strobe. A write restarts the sequence, chooses the four-step or five-step pattern, and sets the interrupt inhibit. The restart is not immediate: it waits for the next half-rate advance edge, so it lands one or two CPU cycles after the write depending on the phase. The external length counter is not part of the block. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `frame_seq_top`

## Requirements
- R1: While reset is asserted and right after it is released, `qtr_n` and `half_n` are 1 and `irq_flag` is 0. The sequence register holds 0x7FFF, the mode is four-step, and the inhibit is off.
- R2: An internal phase toggles on every CPU clock edge and starts at 0 after reset. The register advances only on edges where the phase is 1, which are the 2nd, 4th, 6th and later edges after reset. Each advance shifts the register left by one within 15 bits, and the new bit 0 is bit 14 XOR bit 13.
- R3: On an advance edge where the register equals a quarter-frame entry of the current mode's table, `qtr_n` is low for exactly the following CPU cycle.
- R4: On an advance edge where the register equals a half-frame entry of the current mode's table, `half_n` is low for exactly the following CPU cycle.
- R5: On an advance edge where the register equals the last entry of the current mode's table, the register reloads 0x7FFF instead of shifting. The last entry is the fourth in four-step mode and the fifth in five-step mode.
- R6: A write captures its mode bit and inhibit bit at the write edge. The register is then reloaded to 0x7FFF at the first advance edge strictly after the write. That edge is 1 CPU cycle later if the phase was 0 at the write and 2 cycles later if it was 1. On the reload edge, table decodes are ignored.
- R7: If the mode is five-step on the reload edge of R6, `qtr_n` and `half_n` are both low in the following cycle. If the mode is four-step, neither pulses on that edge.
- R8: `irq_flag` is set when the four-step last entry is reached with the inhibit off. The five-step last entry never sets it.
- R9: A write with the inhibit bit set to 1 clears `irq_flag`. The flag then stays clear for as long as the inhibit is 1.
- R10: A write with the inhibit bit at 0 leaves an already-set `irq_flag` at 1, whatever its mode bit.
- R11: A status read clears `irq_flag` on that edge.
- R12: If a clear (status read or inhibiting write) and a set happen on the same edge, the clear wins and the flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the frame-control register, one cycle per write |
| ctrl_five_step | input | 1 | Mode bit (register bit 7): 1 selects five-step |
| ctrl_irq_off | input | 1 | Inhibit bit (register bit 6): 1 clears and blocks the interrupt flag |
| stat_rd | input | 1 | Status read strobe; clears the interrupt flag |
| qtr_n | output | 1 | Active-low quarter-frame pulse |
| half_n | output | 1 | Active-low half-frame pulse |
| irq_flag | output | 1 | Frame interrupt flag |

## Verification
The hardest case to reach from the ports is a restart whose deferred reload falls on an advance edge that would also decode a table entry or the last entry. The same case must also be reached at both phase parities. The bench uses a short decode table so that a frame is only a few dozen cycles long. It then sweeps the write's offset from reset over every cycle of that frame, for every mode and inhibit combination. This places the pending reload on every possible state at both parities. The length-counter pulses are counted and compared with a cycle-exact model after each write.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int unsigned SEQ_W = 15;
  localparam logic [SEQ_W-1:0] SEQ_SEED = 15'h7FFF;

  function automatic logic [SEQ_W-1:0] seq_step(input logic [SEQ_W-1:0] s);
    return {s[SEQ_W-2:0], s[SEQ_W-1] ^ s[SEQ_W-2]};
  endfunction
endpackage

// File: rtl/fs_phase.sv
module fs_phase (
  input  logic clk,
  input  logic rst_n,
  output logic adv_o
);
  logic ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  assign adv_o = ph_q;

  assert_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> !adv_o);
endmodule

// File: rtl/fs_lfsr.sv
module fs_lfsr
  import fs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             reload_i,
  output logic [SEQ_W-1:0] state_o
);
  logic [SEQ_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= SEQ_SEED;
    else if (adv_i) state_q <= reload_i ? SEQ_SEED : seq_step(state_q);
  end

  assign state_o = state_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(state_o));
  assert_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != '0);
endmodule

// File: rtl/fs_decode.sv
module fs_decode #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 15,
  parameter logic [N*W-1:0] STEPS = '0,
  parameter logic [N-1:0] QMASK = '1,
  parameter logic [N-1:0] HMASK = '0
) (
  input  logic [W-1:0] state_i,
  output logic         q_hit_o,
  output logic         h_hit_o,
  output logic         t_hit_o
);
  logic [N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = (state_i == STEPS[i*W +: W]);
  end

  assign q_hit_o = |(eq & QMASK);
  assign h_hit_o = |(eq & HMASK);
  assign t_hit_o = eq[N-1];
endmodule

// File: rtl/fs_irq.sv
module fs_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic inh_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  assert_inhibit_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inh_i |-> !flag_o);
  assert_fall_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(clr_i));
  assert_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_i));
endmodule

// File: rtl/frame_seq_top.sv
module frame_seq_top
  import fs_pkg::*;
#(
  parameter logic [4*SEQ_W-1:0] STEPS4 = {15'h0A1F, 15'h1F3C, 15'h2C51, 15'h5E20},
  parameter logic [5*SEQ_W-1:0] STEPS5 = {15'h31B6, 15'h0A1F, 15'h1F3C, 15'h2C51, 15'h5E20},
  parameter logic [3:0] QMASK4 = 4'b1111,
  parameter logic [3:0] HMASK4 = 4'b1010,
  parameter logic [4:0] QMASK5 = 5'b10111,
  parameter logic [4:0] HMASK5 = 5'b10010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic ctrl_five_step,
  input  logic ctrl_irq_off,
  input  logic stat_rd,
  output logic qtr_n,
  output logic half_n,
  output logic irq_flag
);
  logic             adv;
  logic [SEQ_W-1:0] state;
  logic             pend_q, mode5_q, inh_q;
  logic             qtr_n_q, half_n_q;
  logic             q4, h4, t4, q5, h5, t5;
  logic             q_sel, h_sel, t_sel;
  logic             reload, term;

  fs_phase u_phase (.clk(clk), .rst_n(rst_n), .adv_o(adv));

  fs_decode #(.N(4), .W(SEQ_W), .STEPS(STEPS4), .QMASK(QMASK4), .HMASK(HMASK4))
    u_dec4 (.state_i(state), .q_hit_o(q4), .h_hit_o(h4), .t_hit_o(t4));

  fs_decode #(.N(5), .W(SEQ_W), .STEPS(STEPS5), .QMASK(QMASK5), .HMASK(HMASK5))
    u_dec5 (.state_i(state), .q_hit_o(q5), .h_hit_o(h5), .t_hit_o(t5));

  always_comb begin
    q_sel = mode5_q ? q5 : q4;
    h_sel = mode5_q ? h5 : h4;
    t_sel = mode5_q ? t5 : t4;
  end

  assign reload = adv & pend_q;
  assign term   = adv & ~pend_q & t_sel;

  fs_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .adv_i(adv),
                  .reload_i(reload | term), .state_o(state));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      mode5_q  <= 1'b0;
      inh_q    <= 1'b0;
      qtr_n_q  <= 1'b1;
      half_n_q <= 1'b1;
    end else begin
      if (ctrl_wr) begin
        pend_q  <= 1'b1;
        mode5_q <= ctrl_five_step;
        inh_q   <= ctrl_irq_off;
      end else if (reload) begin
        pend_q  <= 1'b0;
      end
      qtr_n_q  <= ~(reload ? mode5_q : (adv & q_sel));
      half_n_q <= ~(reload ? mode5_q : (adv & h_sel));
    end
  end

  fs_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_i(term & ~mode5_q & ~inh_q),
    .clr_i(stat_rd | (ctrl_wr & ctrl_irq_off)),
    .inh_i(inh_q),
    .flag_o(irq_flag)
  );

  assign qtr_n  = qtr_n_q;
  assign half_n = half_n_q;

  assert_qtr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !qtr_n |=> qtr_n);
  assert_half_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !half_n |=> half_n);
  assert_pend_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && adv && !ctrl_wr) |=> !pend_q);
endmodule

// File: tb/frame_seq_top_tb_top.sv
`timescale 1ns/1ps
module frame_seq_top_tb_top;
  function automatic logic [14:0] ref_next(input logic [14:0] s);
    logic fb;
    fb = s[14] ^ s[13];
    return ((s << 1) | {14'd0, fb}) & 15'h7FFF;
  endfunction

  function automatic logic [14:0] ref_after(input int n);
    logic [14:0] s;
    s = 15'h7FFF;
    for (int i = 0; i < n; i++) s = ref_next(s);
    return s;
  endfunction

  localparam logic [14:0] A3  = ref_after(3);
  localparam logic [14:0] A6  = ref_after(6);
  localparam logic [14:0] A9  = ref_after(9);
  localparam logic [14:0] A12 = ref_after(12);
  localparam logic [14:0] A15 = ref_after(15);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ctrl_wr, ctrl_five_step, ctrl_irq_off, stat_rd;
  logic qtr_n, half_n, irq_flag;

  frame_seq_top #(
    .STEPS4({A12, A9, A6, A3}),
    .STEPS5({A15, A12, A9, A6, A3})
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_five_step(ctrl_five_step),
    .ctrl_irq_off(ctrl_irq_off), .stat_rd(stat_rd),
    .qtr_n(qtr_n), .half_n(half_n), .irq_flag(irq_flag)
  );

  int nvec = 0, nfail = 0, cyc = 0;
  logic m_ph, m_pend, m_m5, m_inh, m_irq, m_q, m_h;
  logic [14:0] m_s;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_edge(input logic wr, input logic m5, input logic ioff, input logic rd);
    logic rl, tm, qh, hh, th;
    qh = m_m5 ? (m_s == A3 || m_s == A6 || m_s == A9 || m_s == A15)
              : (m_s == A3 || m_s == A6 || m_s == A9 || m_s == A12);
    hh = m_m5 ? (m_s == A6 || m_s == A15) : (m_s == A6 || m_s == A12);
    th = m_m5 ? (m_s == A15) : (m_s == A12);
    rl = m_ph && m_pend;
    tm = m_ph && !m_pend && th;
    m_q = !(rl ? m_m5 : (m_ph && qh));
    m_h = !(rl ? m_m5 : (m_ph && hh));
    if (rd || (wr && ioff)) m_irq = 1'b0;
    else if (tm && !m_m5 && !m_inh) m_irq = 1'b1;
    if (m_ph) m_s = (rl || tm) ? 15'h7FFF : ref_next(m_s);
    if (wr) begin m_pend = 1'b1; m_m5 = m5; m_inh = ioff; end
    else if (rl) m_pend = 1'b0;
    m_ph = !m_ph;
  endtask

  task automatic tick(input logic wr, input logic m5, input logic ioff, input logic rd);
    ctrl_wr = wr; ctrl_five_step = m5; ctrl_irq_off = ioff; stat_rd = rd;
    @(posedge clk);
    model_edge(wr, m5, ioff, rd);
    cyc++;
    @(negedge clk);
    ctrl_wr = 0; ctrl_five_step = 0; ctrl_irq_off = 0; stat_rd = 0;
    chk("R3", {31'd0, qtr_n}, {31'd0, m_q});
    chk("R4", {31'd0, half_n}, {31'd0, m_h});
    chk("R8", {31'd0, irq_flag}, {31'd0, m_irq});
  endtask

  task automatic do_reset();
    rst_n = 0; ctrl_wr = 0; ctrl_five_step = 0; ctrl_irq_off = 0; stat_rd = 0;
    @(negedge clk); @(negedge clk);
    chk("R1", {29'd0, qtr_n, half_n, irq_flag}, 32'b110);
    m_ph = 0; m_pend = 0; m_m5 = 0; m_inh = 0; m_irq = 0; m_q = 1; m_h = 1;
    m_s = 15'h7FFF; cyc = 0;
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    #(64'd200000 * 20);
    nvec++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int expq[8];
    int k;
    expq = '{8, 14, 20, 26, 34, 40, 46, 52};

    // R1, R2, R5, R8: free run from reset in four-step mode
    do_reset();
    chk("R1", {29'd0, qtr_n, half_n, irq_flag}, 32'b110);
    k = 0;
    for (int c = 1; c <= 56; c++) begin
      tick(0, 0, 0, 0);
      if (!qtr_n && k < 8) begin
        chk(k < 4 ? "R2" : "R5", cyc, expq[k]);
        k++;
      end
      if (cyc == 26) chk("R8", {31'd0, irq_flag}, 32'd1);
    end
    chk("R5", k, 8);

    // R10, R9, R11: flag clear rules
    chk("R10", {31'd0, irq_flag}, 32'd1);
    tick(1, 0, 0, 0);
    chk("R10", {31'd0, irq_flag}, 32'd1);
    tick(1, 1, 0, 0);
    chk("R10", {31'd0, irq_flag}, 32'd1);
    tick(1, 0, 1, 0);
    chk("R9", {31'd0, irq_flag}, 32'd0);
    for (int c = 0; c < 60; c++) tick(0, 0, 0, 0);
    chk("R9", {31'd0, irq_flag}, 32'd0);
    tick(1, 0, 0, 0);
    for (int c = 0; c < 30; c++) tick(0, 0, 0, 0);
    chk("R8", {31'd0, irq_flag}, 32'd1);
    tick(0, 0, 0, 1);
    chk("R11", {31'd0, irq_flag}, 32'd0);

    // R12: status read on the same edge as the set
    do_reset();
    for (int c = 1; c < 26; c++) tick(0, 0, 0, 0);
    tick(0, 0, 0, 1);
    chk("R12", {31'd0, irq_flag}, 32'd0);

    // R8: five-step frames never set the flag
    do_reset();
    tick(1, 1, 0, 0);
    for (int c = 0; c < 80; c++) tick(0, 0, 0, 0);
    chk("R8", {31'd0, irq_flag}, 32'd0);

    // R6, R7: write offset sweep over all control combinations
    for (int m = 0; m < 4; m++) begin
      for (int off = 0; off < 32; off++) begin
        int e, rl, first;
        logic five;
        five = m[1];
        do_reset();
        for (int c = 0; c < off; c++) tick(0, 0, 0, 0);
        tick(1, five, m[0], 0);
        e = cyc;
        rl = e + ((e % 2 == 0) ? 2 : 1);
        first = -1;
        for (int c = 0; c < 40; c++) begin
          tick(0, 0, 0, 0);
          if (first < 0 && (five ? !half_n : !qtr_n)) first = cyc;
        end
        if (five) chk("R7", first, rl);
        else      chk("R6", first, rl + 8);
      end
    end

    finish_run();
  end
endmodule